// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer with Chained Returns

This block controls how a small processor enters and leaves interrupt handlers. When the core reaches a decision point, it samples the vectored request lines and a nonmaskable request, and picks the winner. It then runs a fixed micro-sequence: it writes the return address and the flags word to a descending stack and fetches the handler address from a vector table. Finally it hands that address to the program counter through a one-cycle load strobe.

When the core signals a return from interrupt, the block takes one of two paths. It can pop the flags word and the return address in reverse order. Or, if the chain-enable flag is set and a vectored request is waiting, it jumps straight to the next handler without touching the stack.

The flags register lives in the block. Software can rewrite it at any idle moment, and the sequencer obeys whatever chain-enable value it finds there at the next return.

Top module: `int_seq_top`

## Requirements
- R1: After synchronous reset, `busy` is 0, `flags_q` is 0, `sp` is `SP_INIT`, and `pc_load`, `irq_ack`, `nmi_ack`, `stk_we`, `stk_re` and `vec_re` are all 0.
- R2: A `decide` pulse while idle is accepted for the vectored lines only when flags bit 7 (global enable) is 1 and some `irq_req` bit is set. The line with the lowest index wins. In the next cycle `irq_ack` shows a one-cycle one-hot pulse for that line. Otherwise nothing starts and no acknowledge appears.
- R3: An accepted entry writes `ret_pc` at SP-4 in the cycle after `decide`. In the following cycle it writes the pre-entry flags, zero-extended, at SP-8. Each write lowers SP by 4.
- R4: In the cycle after the flags write, flags bit 1 (chain enable) holds the pre-entry value of bit 7, and bit 7 is 0.
- R5: Three cycles after `decide`, `vec_re` is 1 with `vec_addr` = `VEC_BASE` + 4 × index. In the next cycle `pc_load` is 1 and `pc_out` equals the returned table word. The cycle after that, `busy` is 0.
- R6: An `iret` pulse while idle chains when flags bit 1 is 1 and some `irq_req` bit is set. In the next cycle bit 7 is 0, the lowest-index line is acknowledged, and the vector for that line is read with no stack access. `pc_load` follows one cycle later, and SP is unchanged.
- R7: Any other `iret` pulse while idle reads the flags word at SP, then the return address at SP+4. In the third cycle the flags register holds the popped low byte, `pc_load` is 1 with `pc_out` equal to the popped address, and SP has risen by 8.
- R8: `nmi_req` with `decide` while idle is taken whatever bit 7 holds, and ahead of all vectored lines. It pulses `nmi_ack` and uses table index `NREQ`. If bit 7 was 0, the copy rule leaves bit 1 at 0, so the matching return pops instead of chaining.
- R9: A `flags_we` write while idle replaces the flags register in the next cycle. The chain-enable bit it sets or clears decides the path of the next `iret`.
- R10: While `busy` is 1, `decide` and `iret` pulses are ignored. The running sequence completes unchanged.
- R11: If `iret` and `decide` arrive together while idle, the return is served and the entry request is dropped, including a pending nonmaskable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NREQ | Vectored request lines, index 0 highest priority |
| nmi_req | input | 1 | Nonmaskable request |
| decide | input | 1 | Decision-point strobe from the core |
| iret | input | 1 | Return-from-interrupt strobe |
| ret_pc | input | AW | Address to resume at after the handler |
| irq_ack | output | NREQ | One-hot acknowledge pulse |
| nmi_ack | output | 1 | Nonmaskable acknowledge pulse |
| busy | output | 1 | A sequence is running |
| flags_we | input | 1 | Software write strobe for the flags register |
| flags_wd | input | 8 | Software write data |
| flags_q | output | 8 | Flags register (bit 7 global enable, bit 1 chain enable) |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe; data is expected one cycle later |
| stk_addr | output | AW | Stack byte address |
| stk_wdata | output | DW | Stack write data |
| stk_rdata | input | DW | Stack read data |
| vec_re | output | 1 | Vector table read strobe; data is expected one cycle later |
| vec_addr | output | AW | Vector table byte address |
| vec_rdata | input | DW | Vector table read data |
| pc_load | output | 1 | Program counter load strobe |
| pc_out | output | AW | New program counter value |
| sp | output | AW | Current stack pointer |

## Verification
The bench builds the block with its defaults: eight request lines, 32-bit addresses and data, vector base 0x100 and stack top 0x1000. With these values every line plus the nonmaskable slot at index 8 can be reached by random request patterns. Nested entries, where software re-enables interrupts inside a handler, stay within the bench's 1024-word stack model. The bench can also run random chains of several returns in a row and check the stack addresses and popped words against its own model.

// File: rtl/int_seq_pkg.sv
// Shared constants and state encoding for the interrupt sequencer.
// Assumes an 8-bit flags register with fixed bit meanings.
package int_seq_pkg;
    localparam int FLAGS_W   = 8;
    localparam int FLB_CHAIN = 1;   // chain-enable bit
    localparam int FLB_GIE   = 7;   // global interrupt enable bit

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_PC,
        S_PUSH_FL,
        S_VEC_RD,
        S_VEC_LD,
        S_POP_FL,
        S_POP_PC,
        S_RET_LD
    } seq_state_t;
endpackage

// File: rtl/int_prio_pick.sv
// Fixed-priority picker: the lowest set index wins.
// Assumes IW is wide enough to hold N-1.
module int_prio_pick #(
    parameter int N  = 8,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    logic          hit [0:N];
    logic [IW-1:0] sel [0:N];

    assign hit[N] = 1'b0;
    assign sel[N] = '0;

    // Ripple from the top index down, so that lower indices override.
    for (genvar i = N - 1; i >= 0; i--) begin : g_chain
        assign hit[i] = req_i[i] | hit[i+1];
        assign sel[i] = req_i[i] ? IW'(i) : sel[i+1];
    end

    assign found_o = hit[0];
    assign idx_o   = sel[0];
endmodule

// File: rtl/int_flags_reg.sv
// Flags register. Sequencer updates take precedence over a software write
// made in the same cycle. Assumes only one sequencer update is active at a time.
module int_flags_reg
    import int_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_we_i,
    input  logic [FLAGS_W-1:0] sw_wd_i,
    input  logic               take_i,
    input  logic               chain_i,
    input  logic               restore_i,
    input  logic [FLAGS_W-1:0] restore_d_i,
    output logic [FLAGS_W-1:0] flags_o
);
    logic [FLAGS_W-1:0] fl_q;

    // Apply entry copy, chain clear, pop restore or software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else if (take_i) begin
            fl_q[FLB_CHAIN] <= fl_q[FLB_GIE];
            fl_q[FLB_GIE]   <= 1'b0;
        end else if (chain_i) begin
            fl_q[FLB_GIE] <= 1'b0;
        end else if (restore_i) begin
            fl_q <= restore_d_i;
        end else if (sw_we_i) begin
            fl_q <= sw_wd_i;
        end
    end

    assign flags_o = fl_q;

    a_r4_take_copies_enable: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (flags_o[FLB_CHAIN] == $past(flags_o[FLB_GIE])) && !flags_o[FLB_GIE]);
    a_r6_chain_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        chain_i |=> !flags_o[FLB_GIE]);
endmodule

// File: rtl/int_sp_unit.sv
// Stack pointer for a full-descending stack of STEP-byte words.
// Assumes dec_i and inc_i are never both high.
module int_sp_unit #(
    parameter int               AW      = 32,
    parameter int               STEP    = 4,
    parameter logic [AW-1:0]    SP_INIT = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_i,
    input  logic          inc_i,
    output logic [AW-1:0] sp_o
);
    logic [AW-1:0] sp_q;

    // Move the pointer one word per push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)     sp_q <= SP_INIT;
        else if (dec_i) sp_q <= sp_q - AW'(STEP);
        else if (inc_i) sp_q <= sp_q + AW'(STEP);
    end

    assign sp_o = sp_q;

    a_r3_sp_drops_per_push: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |=> sp_o == $past(sp_o) - AW'(STEP));
    a_r7_sp_rises_per_pop: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> sp_o == $past(sp_o) + AW'(STEP));
endmodule

// File: rtl/int_seq_top.sv
// Interrupt entry/return sequencer. At a decision point it takes the
// nonmaskable request, or the lowest-index vectored request when global enable
// is set. It pushes the return PC and then the flags, and loads the PC from the
// vector table. On return it either chains to a pending handler or pops the
// saved state. Assumes one-cycle read latency on the stack and vector ports,
// and AW == DW.
module int_seq_top
    import int_seq_pkg::*;
#(
    parameter int            NREQ     = 8,
    parameter int            AW       = 32,
    parameter int            DW       = 32,
    parameter logic [AW-1:0] VEC_BASE = 32'h0000_0100,
    parameter logic [AW-1:0] SP_INIT  = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    irq_req,
    input  logic               nmi_req,
    input  logic               decide,
    input  logic               iret,
    input  logic [AW-1:0]      ret_pc,
    output logic [NREQ-1:0]    irq_ack,
    output logic               nmi_ack,
    output logic               busy,
    input  logic               flags_we,
    input  logic [FLAGS_W-1:0] flags_wd,
    output logic [FLAGS_W-1:0] flags_q,
    output logic               stk_we,
    output logic               stk_re,
    output logic [AW-1:0]      stk_addr,
    output logic [DW-1:0]      stk_wdata,
    input  logic [DW-1:0]      stk_rdata,
    output logic               vec_re,
    output logic [AW-1:0]      vec_addr,
    input  logic [DW-1:0]      vec_rdata,
    output logic               pc_load,
    output logic [AW-1:0]      pc_out,
    output logic [AW-1:0]      sp
);
    localparam int IW   = $clog2(NREQ + 1);
    localparam int STEP = DW / 8;

    seq_state_t        state_q, state_d;
    logic [IW-1:0]     idx_q, pick_idx;
    logic [AW-1:0]     pc_save_q;
    logic [NREQ-1:0]   ack_q;
    logic              nmi_ack_q;
    logic              pick_found, idle;
    logic              take_nmi, take_irq, take_go, chain_go, pop_go;

    int_prio_pick #(.N(NREQ), .IW(IW)) u_pick (
        .req_i   (irq_req),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    // Decisions are made only from idle; iret wins over decide.
    assign idle     = (state_q == S_IDLE);
    assign chain_go = idle && iret && flags_q[FLB_CHAIN] && pick_found;
    assign pop_go   = idle && iret && !chain_go;
    assign take_nmi = idle && !iret && decide && nmi_req;
    assign take_irq = idle && !iret && decide && !nmi_req && flags_q[FLB_GIE] && pick_found;
    assign take_go  = take_nmi || take_irq;

    // Next-state selection for the micro-sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take_go)       state_d = S_PUSH_PC;
                else if (chain_go) state_d = S_VEC_RD;
                else if (pop_go)   state_d = S_POP_FL;
            end
            S_PUSH_PC: state_d = S_PUSH_FL;
            S_PUSH_FL: state_d = S_VEC_RD;
            S_VEC_RD:  state_d = S_VEC_LD;
            S_VEC_LD:  state_d = S_IDLE;
            S_POP_FL:  state_d = S_POP_PC;
            S_POP_PC:  state_d = S_RET_LD;
            S_RET_LD:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State, latched vector index, saved return address and acknowledge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            idx_q     <= '0;
            pc_save_q <= '0;
            ack_q     <= '0;
            nmi_ack_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            ack_q     <= (take_irq || chain_go) ? (NREQ'(1) << pick_idx) : '0;
            nmi_ack_q <= take_nmi;
            if (take_nmi)                 idx_q <= IW'(NREQ);
            else if (take_irq || chain_go) idx_q <= pick_idx;
            if (take_go)                  pc_save_q <= ret_pc;
        end
    end

    int_flags_reg u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_we_i     (flags_we),
        .sw_wd_i     (flags_wd),
        .take_i      (state_q == S_PUSH_FL),
        .chain_i     (chain_go),
        .restore_i   (state_q == S_POP_PC),
        .restore_d_i (stk_rdata[FLAGS_W-1:0]),
        .flags_o     (flags_q)
    );

    int_sp_unit #(.AW(AW), .STEP(STEP), .SP_INIT(SP_INIT)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec_i (stk_we),
        .inc_i (stk_re),
        .sp_o  (sp)
    );

    // Memory-side strobes and addresses, driven from the current state.
    always_comb begin
        stk_we    = (state_q == S_PUSH_PC) || (state_q == S_PUSH_FL);
        stk_re    = (state_q == S_POP_FL) || (state_q == S_POP_PC);
        stk_addr  = stk_we ? (sp - AW'(STEP)) : sp;
        stk_wdata = (state_q == S_PUSH_PC) ? DW'(pc_save_q) : DW'(flags_q);
        vec_re    = (state_q == S_VEC_RD);
        vec_addr  = VEC_BASE + AW'(idx_q) * AW'(STEP);
        pc_load   = (state_q == S_VEC_LD) || (state_q == S_RET_LD);
        pc_out    = (state_q == S_RET_LD) ? AW'(stk_rdata) : AW'(vec_rdata);
    end

    assign irq_ack = ack_q;
    assign nmi_ack = nmi_ack_q;
    assign busy    = !idle;

    a_r2_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_ack, irq_ack}));
    a_r3_no_read_write_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we && stk_re));
    a_r5_vector_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        vec_re |=> pc_load && !stk_re);
    a_r6_chain_skips_stack: assert property (@(posedge clk) disable iff (!rst_n)
        chain_go |=> !stk_we && !stk_re && vec_re);
    a_r7_pop_flags_then_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POP_FL) |=> stk_re && (stk_addr == $past(stk_addr) + AW'(STEP)));
    a_r10_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (decide || iret)) |=> (irq_ack == '0 || $past(state_q) == S_IDLE));
endmodule

// File: tb/int_seq_top_test.sv
module int_seq_top_test;
    localparam logic [31:0] VBASE = 32'h0000_0100;
    localparam logic [31:0] SPI   = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_req = '0;
    logic        nmi_req = 1'b0, decide = 1'b0, iret = 1'b0;
    logic [31:0] ret_pc = '0;
    logic [7:0]  irq_ack;
    logic        nmi_ack, busy;
    logic        flags_we = 1'b0;
    logic [7:0]  flags_wd = '0, flags_q;
    logic        stk_we, stk_re, vec_re, pc_load;
    logic [31:0] stk_addr, stk_wdata, vec_addr, pc_out, sp;
    logic [31:0] stk_rdata = '0, vec_rdata = '0;

    int_seq_top uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .decide(decide), .iret(iret), .ret_pc(ret_pc), .irq_ack(irq_ack),
        .nmi_ack(nmi_ack), .busy(busy), .flags_we(flags_we), .flags_wd(flags_wd),
        .flags_q(flags_q), .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
        .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .vec_re(vec_re),
        .vec_addr(vec_addr), .vec_rdata(vec_rdata), .pc_load(pc_load),
        .pc_out(pc_out), .sp(sp)
    );

    always #5 clk = ~clk;

    // Memory models: one-cycle read latency.
    logic [31:0] smem [0:1023];
    always @(posedge clk) begin
        if (stk_we) smem[stk_addr[11:2]] <= stk_wdata;
        if (stk_re) stk_rdata <= smem[stk_addr[11:2]];
        if (vec_re) vec_rdata <= 32'hC000_0000 ^ vec_addr;
    end

    int n_chk = 0, n_bad = 0;
    logic [7:0]  m_fl = '0;
    logic [31:0] m_sp = SPI;
    logic [31:0] sv_pc [0:15];
    logic [7:0]  sv_fl [0:15];
    int dep = 0;
    bit m_acc;

    function automatic int prio(input logic [7:0] r);
        for (int i = 0; i < 8; i++) if (r[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] exp_vec(input int idx);
        return 32'hC000_0000 ^ (VBASE + 32'(idx) * 32'd4);
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic sw_write(input logic [7:0] v);
        flags_we = 1'b1; flags_wd = v;
        @(negedge clk);
        flags_we = 1'b0;
        @(negedge clk);
        m_fl = v;
        chk("R9 flags write", {24'd0, flags_q}, {24'd0, m_fl});
    endtask

    // Decision point; poke drives iret/decide during the busy cycles (R10).
    task automatic do_take(input logic [7:0] r, input bit nmi, input logic [31:0] pc, input bit poke);
        int idx;
        irq_req = r; nmi_req = nmi; ret_pc = pc; decide = 1'b1;
        m_acc = nmi || (m_fl[7] && r != 0);
        idx = nmi ? 8 : prio(r);
        @(negedge clk);
        decide = poke; iret = poke;
        if (!m_acc) begin
            decide = 1'b0; iret = 1'b0;
            chk("R2 refused busy", {31'd0, busy}, 32'd0);
            chk("R2 refused ack", {24'd0, irq_ack}, 32'd0);
            chk("R2 refused sp", sp, m_sp);
            return;
        end
        chk("R2 ack", {23'd0, nmi_ack, irq_ack}, nmi ? 32'h100 : (32'd1 << idx));
        chk("R3 push pc we", {31'd0, stk_we}, 32'd1);
        chk("R3 push pc addr", stk_addr, m_sp - 4);
        chk("R3 push pc data", stk_wdata, pc);
        @(negedge clk);
        decide = 1'b0; iret = 1'b0;
        chk("R3 push flags addr", stk_addr, m_sp - 8);
        chk("R3 push flags data", stk_wdata, {24'd0, m_fl});
        sv_pc[dep] = pc; sv_fl[dep] = m_fl; dep++;
        m_sp -= 8;
        m_fl[1] = m_fl[7]; m_fl[7] = 1'b0;
        @(negedge clk);
        chk("R4 flags after entry", {24'd0, flags_q}, {24'd0, m_fl});
        chk("R5 vec read", {31'd0, vec_re}, 32'd1);
        chk("R5 vec addr", vec_addr, VBASE + 32'(idx) * 4);
        @(negedge clk);
        chk("R5 pc load", {31'd0, pc_load}, 32'd1);
        chk("R5 pc value", pc_out, exp_vec(idx));
        @(negedge clk);
        chk("R5 idle again", {31'd0, busy}, 32'd0);
        chk("R3 sp after entry", sp, m_sp);
    endtask

    // Return; with_dec raises decide and nmi_req together with iret (R11).
    task automatic do_iret(input logic [7:0] r, input bit with_dec);
        int idx;
        irq_req = r; iret = 1'b1; decide = with_dec; nmi_req = with_dec;
        @(negedge clk);
        iret = 1'b0; decide = 1'b0; nmi_req = 1'b0;
        chk("R11 no nmi ack", {31'd0, nmi_ack}, 32'd0);
        if (m_fl[1] && r != 0) begin
            idx = prio(r);
            m_fl[7] = 1'b0;
            chk("R6 no stack", {30'd0, stk_we, stk_re}, 32'd0);
            chk("R6 ack", {24'd0, irq_ack}, 32'd1 << idx);
            chk("R6 vec addr", vec_re ? vec_addr : 32'hFFFF_FFFF, VBASE + 32'(idx) * 4);
            chk("R6 enable cleared", {24'd0, flags_q}, {24'd0, m_fl});
            @(negedge clk);
            chk("R6 pc load", {31'd0, pc_load}, 32'd1);
            chk("R6 pc value", pc_out, exp_vec(idx));
            chk("R6 sp kept", sp, m_sp);
        end else begin
            chk("R7 pop flags", {31'd0, stk_re}, 32'd1);
            chk("R7 pop flags addr", stk_addr, m_sp);
            chk("R7 no ack", {24'd0, irq_ack}, 32'd0);
            @(negedge clk);
            chk("R7 pop pc addr", stk_re ? stk_addr : 32'hFFFF_FFFF, m_sp + 4);
            @(negedge clk);
            dep--;
            m_fl = sv_fl[dep]; m_sp += 8;
            chk("R7 pc load", {31'd0, pc_load}, 32'd1);
            chk("R7 pc value", pc_out, sv_pc[dep]);
            chk("R7 flags restored", {24'd0, flags_q}, {24'd0, m_fl});
        end
        @(negedge clk);
        chk("R7 idle after return", {31'd0, busy}, 32'd0);
        chk("R7 sp after return", sp, m_sp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int unsigned s;
        s = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 flags", {24'd0, flags_q}, 32'd0);
        chk("R1 sp", sp, SPI);
        chk("R1 strobes", {24'd0, pc_load, stk_we, stk_re, vec_re, nmi_ack, 3'd0}, 32'd0);
        chk("R1 ack", {24'd0, irq_ack}, 32'd0);

        // R2: refused with enable clear.
        do_take(8'h24, 1'b0, 32'h1234, 1'b0);
        // R8: nmi with enable clear, return pops even with requests pending.
        do_take(8'h10, 1'b1, 32'h0000_2000, 1'b0);
        do_iret(8'h10, 1'b0);
        // R2/R4/R6: simultaneous requests, lowest wins; chained return.
        sw_write(8'h80);
        do_take(8'hA4, 1'b0, 32'h0000_3000, 1'b0);
        do_iret(8'h28, 1'b0);
        do_iret(8'h00, 1'b0);
        // R9: software clears chain enable, return pops.
        sw_write(8'h80);
        do_take(8'h01, 1'b0, 32'h0000_4000, 1'b0);
        sw_write(flags_q & 8'hFD);
        do_iret(8'h40, 1'b0);
        // R9: software sets chain enable where the copy gave 0.
        do_take(8'h00, 1'b1, 32'h0000_5000, 1'b0);
        sw_write(flags_q | 8'h02);
        do_iret(8'h80, 1'b0);
        do_iret(8'h00, 1'b0);
        // R10: pulses during the sequence are ignored; nesting of two.
        sw_write(8'h80);
        do_take(8'h02, 1'b0, 32'h0000_6000, 1'b1);
        sw_write(flags_q | 8'h80);
        do_take(8'h01, 1'b0, 32'h0000_7000, 1'b0);
        // R11: return wins over a coincident nonmaskable decide.
        do_iret(8'h00, 1'b1);
        do_iret(8'h00, 1'b0);

        // Random mix.
        for (int it = 0; it < 60; it++) begin
            r = 8'($urandom);
            sw_write({($urandom % 4) != 0, 5'($urandom), 2'($urandom)});
            do_take(($urandom % 6 == 0) ? 8'h00 : r, ($urandom % 8) == 0, $urandom, 1'b0);
            while (dep > 0) begin
                r = 8'($urandom) | 8'h01 << ($urandom % 8);
                do_iret(($urandom % 3 == 0) ? 8'h00 : r, 1'b0);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule